// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Register

This block is the read-only status byte of a real-time-clock peripheral. It collects one-cycle event pulses from the watchdog, test-mode entry, power-sense and periodic tick sources. It also compares the running seconds, minutes and hours against the alarm settings, and raises the alarm flag on the cycle the three fields come to agree. The flags are sticky. The block drives the live status byte and a combined interrupt request.

A read strobe that decodes to the register address captures the byte into a read-data register, then clears the flags. The power-sense flag is the exception: it survives reads and is cleared only by power-on reset or by a dedicated clear pulse from the power-sense logic. Power-on reset clears the event flags. It sets a first-time-up flag that tells software the time and RAM contents are not yet valid. All pins are plain control and status signals, so there is no back-pressure; a read completes in one cycle.

Top module: `rtc_irq_status`

## Requirements
- R1: After power-on reset (`rst_n` low) the status byte is 0x10 (only first-time-up, bit 4, set) and `irq_o` is 0.
- R2: Only a read with `addr_i` equal to 0x30 captures or clears. A read at any other address leaves the flags and `rd_data_o` unchanged.
- R3: Bit positions are fixed: bit 6 watchdog fault, bit 5 test mode, bit 4 first-time up, bit 3 interrupt true, bit 2 power-sense, bit 1 alarm, bit 0 periodic clock; bit 7 reads 0. A one-cycle pulse on a source sets its bit on the next clock edge.
- R4: A read at 0x30 loads `rd_data_o` with the status byte as it was before the read. From the next cycle, every flag except power-sense is 0, including first-time up.
- R5: The power-sense flag is kept across reads. It is cleared only by a `psense_clr_i` pulse or by power-on reset.
- R6: The alarm flag is set once, on the cycle where seconds, minutes and hours first all equal the alarm values. A partial match does not set it. A match that persists does not set it again after a clearing read; a new match after leaving the equal state does.
- R7: Bit 3 and `irq_o` are 1 exactly when at least one of bits 2, 1 or 0 is 1.
- R8: An event arriving in the same cycle as a clear (read or power-sense clear) wins: the flag is 1 afterwards.
- R9: A write strobe at 0x30 has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wdog_evt_i | input | 1 | Watchdog fault pulse |
| test_evt_i | input | 1 | Test-mode entry pulse |
| tick_evt_i | input | 1 | Periodic clock interrupt pulse |
| psense_evt_i | input | 1 | Power-sense interrupt pulse |
| psense_clr_i | input | 1 | Clear pulse for the power-sense flag |
| now_sec_i | input | TW | Current seconds |
| now_min_i | input | TW | Current minutes |
| now_hr_i | input | TW | Current hours |
| alm_sec_i | input | TW | Alarm seconds |
| alm_min_i | input | TW | Alarm minutes |
| alm_hr_i | input | TW | Alarm hours |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe (ignored by the register) |
| addr_i | input | AW | Access address |
| rd_data_o | output | 8 | Byte captured by the last read at 0x30 |
| status_o | output | 8 | Live status byte |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The sources are pulsed one at a time and together. This shows that each lands on its own bit and feeds the interrupt-true bit only when it is one of the three interrupt sources. The alarm compare is driven with times that agree in two fields only, then in all three, then held equal across a read, then moved away and back. This separates a full three-field compare from a partial one and edge detection from level detection. Reads at a neighbouring address, writes at 0x30, and events coinciding with reads or the power-sense clear show that the decode is exact, that the read returns the pre-clear byte, and that setting has priority over clearing.

// File: rtl/rtc_stat_pkg.sv
package rtc_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int NFLAG   = 6;
  // flag slot indices inside the sticky vector
  localparam int F_CLK   = 0;
  localparam int F_ALM   = 1;
  localparam int F_PS    = 2;
  localparam int F_FTU   = 3;
  localparam int F_TEST  = 4;
  localparam int F_WDOG  = 5;
  // status byte bit positions
  localparam int B_CLK   = 0;
  localparam int B_ALM   = 1;
  localparam int B_PS    = 2;
  localparam int B_INT   = 3;
  localparam int B_FTU   = 4;
  localparam int B_TEST  = 5;
  localparam int B_WDOG  = 6;
endpackage

// File: rtl/stat_flag.sv
module stat_flag #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // set beats clear in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && clr_i) |=> !q_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int TW = 8,
  parameter int NF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NF*TW-1:0] now_i,
  input  logic [NF*TW-1:0] alm_i,
  output logic             hit_o
);
  logic [NF-1:0] fld_eq;
  logic          match, match_q;

  for (genvar g = 0; g < NF; g++) begin : g_fld
    assign fld_eq[g] = (now_i[g*TW +: TW] == alm_i[g*TW +: TW]);
  end

  assign match = &fld_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match;
  end

  assign hit_o = match && !match_q;

  p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_stat_pkg::*;
#(
  parameter int          TW        = 8,
  parameter int          AW        = 8,
  parameter logic [7:0]  STAT_ADDR = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wdog_evt_i,
  input  logic          test_evt_i,
  input  logic          tick_evt_i,
  input  logic          psense_evt_i,
  input  logic          psense_clr_i,
  input  logic [TW-1:0] now_sec_i,
  input  logic [TW-1:0] now_min_i,
  input  logic [TW-1:0] now_hr_i,
  input  logic [TW-1:0] alm_sec_i,
  input  logic [TW-1:0] alm_min_i,
  input  logic [TW-1:0] alm_hr_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    rd_data_o,
  output logic [7:0]    status_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] HIT_ADDR = AW'(STAT_ADDR);

  logic             rd_hit, wr_hit, alarm_hit;
  logic [NFLAG-1:0] set_v, clr_v, flag_q;

  assign rd_hit = rd_en_i && (addr_i == HIT_ADDR);
  assign wr_hit = wr_en_i && (addr_i == HIT_ADDR);

  alarm_cmp #(.TW(TW), .NF(3)) u_alarm (
    .clk   (clk),
    .rst_n (rst_n),
    .now_i ({now_hr_i, now_min_i, now_sec_i}),
    .alm_i ({alm_hr_i, alm_min_i, alm_sec_i}),
    .hit_o (alarm_hit)
  );

  always_comb begin
    set_v         = '0;
    set_v[F_CLK]  = tick_evt_i;
    set_v[F_ALM]  = alarm_hit;
    set_v[F_PS]   = psense_evt_i;
    set_v[F_FTU]  = 1'b0;
    set_v[F_TEST] = test_evt_i;
    set_v[F_WDOG] = wdog_evt_i;
    clr_v         = {NFLAG{rd_hit}};
    clr_v[F_PS]   = psense_clr_i;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    stat_flag #(.RST_VAL(i == F_FTU)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .q_o   (flag_q[i])
    );
  end

  assign irq_o = flag_q[F_PS] | flag_q[F_ALM] | flag_q[F_CLK];

  always_comb begin
    status_o         = '0;
    status_o[B_CLK]  = flag_q[F_CLK];
    status_o[B_ALM]  = flag_q[F_ALM];
    status_o[B_PS]   = flag_q[F_PS];
    status_o[B_INT]  = irq_o;
    status_o[B_FTU]  = flag_q[F_FTU];
    status_o[B_TEST] = flag_q[F_TEST];
    status_o[B_WDOG] = flag_q[F_WDOG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data_o <= '0;
    else if (rd_hit) rd_data_o <= status_o;
  end

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> rd_data_o == $past(status_o));
  p_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> $stable(rd_data_o));
  p_ps_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[B_PS] && !psense_clr_i) |=> status_o[B_PS]);
  p_alarm_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !alarm_hit) |=> !status_o[B_ALM]);
  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !rd_hit && !psense_clr_i && set_v == '0) |=> status_o == $past(status_o));
endmodule

// File: tb/rtc_irq_status_tb.sv
module rtc_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wdog_evt_i = 0, test_evt_i = 0, tick_evt_i = 0;
  logic       psense_evt_i = 0, psense_clr_i = 0;
  logic [7:0] now_sec_i = 8'h00, now_min_i = 8'h00, now_hr_i = 8'h00;
  logic [7:0] alm_sec_i = 8'h59, alm_min_i = 8'h59, alm_hr_i = 8'h23;
  logic       rd_en_i = 0, wr_en_i = 0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] rd_data_o, status_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rtc_irq_status u_dut (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a);
    rd_en_i = 1; addr_i = a;
    step();
    rd_en_i = 0; addr_i = 8'h00;
  endtask

  task automatic t_reset();
    check("R1 status after reset", status_o, 8'h10);
    check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    do_read(8'h30);
    check("R4 read returns pre-clear byte", rd_data_o, 8'h10);
    check("R4 first-time up cleared by read", status_o, 8'h00);
  endtask

  task automatic t_events();
    wdog_evt_i = 1; step(); wdog_evt_i = 0;
    check("R3 watchdog bit 6", status_o, 8'h40);
    check("R7 irq not raised by watchdog", {7'd0, irq_o}, 8'h00);
    test_evt_i = 1; step(); test_evt_i = 0;
    check("R3 test bit 5", status_o, 8'h60);
    tick_evt_i = 1; step(); tick_evt_i = 0;
    check("R3 clock bit 0 and R7 bit 3", status_o, 8'h69);
    check("R7 irq from clock", {7'd0, irq_o}, 8'h01);
    do_read(8'h30);
    check("R4 captured byte", rd_data_o, 8'h69);
    check("R4 cleared after read", status_o, 8'h00);
  endtask

  task automatic t_addr_write();
    tick_evt_i = 1; step(); tick_evt_i = 0;
    do_read(8'h31);
    check("R2 other address keeps flags", status_o, 8'h09);
    check("R2 other address keeps rd_data", rd_data_o, 8'h69);
    wr_en_i = 1; addr_i = 8'h30; step(); wr_en_i = 0; addr_i = 8'h00;
    check("R9 write has no effect", status_o, 8'h09);
    do_read(8'h30);
    check("R2 matching address clears", status_o, 8'h00);
    check("R2 matching address captures", rd_data_o, 8'h09);
  endtask

  task automatic t_psense();
    psense_evt_i = 1; step(); psense_evt_i = 0;
    check("R5 power-sense bit 2", status_o, 8'h0C);
    do_read(8'h30);
    check("R5 read capture", rd_data_o, 8'h0C);
    check("R5 kept across read", status_o, 8'h0C);
    check("R7 irq held by power-sense", {7'd0, irq_o}, 8'h01);
    psense_clr_i = 1; step(); psense_clr_i = 0;
    check("R5 explicit clear", status_o, 8'h00);
    check("R7 irq drops", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_alarm();
    alm_hr_i = 8'h12; alm_min_i = 8'h34; alm_sec_i = 8'h56;
    now_hr_i = 8'h12; now_min_i = 8'h34; now_sec_i = 8'h55;
    step();
    check("R6 seconds differ no alarm", status_o, 8'h00);
    now_min_i = 8'h35; now_sec_i = 8'h56;
    step();
    check("R6 minutes differ no alarm", status_o, 8'h00);
    now_min_i = 8'h34;
    step();
    check("R6 full match sets alarm", status_o, 8'h0A);
    do_read(8'h30);
    check("R6 read capture", rd_data_o, 8'h0A);
    step(); step();
    check("R6 held match does not re-set", status_o, 8'h00);
    now_sec_i = 8'h57; step();
    now_sec_i = 8'h56; step();
    check("R6 new match sets again", status_o, 8'h0A);
    do_read(8'h30);
    now_sec_i = 8'h00;
    step();
  endtask

  task automatic t_coincide();
    tick_evt_i = 1; rd_en_i = 1; addr_i = 8'h30;
    step();
    tick_evt_i = 0; rd_en_i = 0; addr_i = 8'h00;
    check("R8 read returns old byte", rd_data_o, 8'h00);
    check("R8 event beats read clear", status_o, 8'h09);
    psense_evt_i = 1; psense_clr_i = 1;
    step();
    psense_evt_i = 0; psense_clr_i = 0;
    check("R8 power-sense beats its clear", status_o, 8'h0D);
    psense_clr_i = 1; step(); psense_clr_i = 0;
    do_read(8'h30);
    check("R8 cleanup", status_o, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_events();
    t_addr_write();
    t_psense();
    t_alarm();
    t_coincide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule